// File: doc/BRIEF.md
# Fault-tolerant bit-stream multiplier

This block multiplies two unsigned operands without any clock. Every partial-product bit `a[i]&b[k]` is copied several times into a unary stream for its weight column, and each column also gets a few bits tied high. The decoder for a column counts the ones in it and divides by the copy factor. Because of this, a limited number of bits flipped at the same time inside a column leaves the decoded column value unchanged. A weighted adder then shifts each decoded column value by its weight and sums them into the binary product.

With the default parameters (8-bit operands, 8 copies, 4 padding ones) there are 15 columns and 572 stream bits. A fault mask input is XORed onto the stream in front of the counters, so upsets can be injected directly. The stream the counters actually see, after the mask, is brought out on a port so it can be inspected. The counters and the adder are not protected.

Stream layout: the columns are packed from bit 0 upward in order of weight, 0 through 14. Column j is `8*P(j)+4` bits wide, where `P(j)=min(j+1,15-j)`. Inside a column, the lowest 4 bits are the constant ones. After them come the pairs, ordered by ascending `i`, starting at `i=max(0,j-7)`, with `k=j-i`. Each pair fills 8 adjacent bits.

Top module: `bsm_multiplier`

## Requirements
- R1: With an all-zero fault mask, `product` equals `opA*opB` for every pair of 8-bit unsigned operands.
- R2: With an all-zero mask, `rawStream` matches the layout given above bit for bit: column order, column offsets, pair order and 8-fold replication.
- R3: The 4 lowest bits of every column are constant ones, so they appear on `rawStream` as the inverse of the matching `faultMask` bits.
- R4: With an all-zero mask, the number of ones on `rawStream` equals `8*popcount(opA)*popcount(opB)+60`.
- R5: `rawStream` equals the clean stream XOR `faultMask`, bit by bit.
- R6: Flipping up to 3 zero bits to one in every column at once leaves `product` equal to `opA*opB`.
- R7: Flipping up to 4 one bits to zero in every column at once leaves `product` equal to `opA*opB`.
- R8: Any mix of at most 3 upward and at most 4 downward flips per column, in all columns at once, leaves `product` equal to `opA*opB`.
- R9: A net of 4 upward flips in column j, with the other columns clean, gives `product = (opA*opB + 2^j) mod 2^16`.
- R10: A net of 5 downward flips in a column j whose pair sum is at least 1, with the other columns clean, gives `product = (opA*opB - 2^j) mod 2^16`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 8 | First unsigned operand |
| opB | input | 8 | Second unsigned operand |
| faultMask | input | 572 | Bits XORed onto the stream in front of the counters |
| rawStream | output | 572 | Stream after the mask, as seen by the counters |
| product | output | 16 | Decoded binary product |

## Verification
The hardest condition to reach from the ports is one where the flip budget is exhausted in every column at once, with exactly the tolerated number of upward and downward flips, and where each flip lands on a bit whose clean value is known. The bench models the clean stream for the operands it applies. It builds each mask one column at a time: upward flips are placed only on positions that are zero in the model, and downward flips only on positions that are one, starting from a position that rotates between iterations. Operands from an LFSR then sweep this across many stream contents. One flip beyond each limit is also tested, and the product must then move by exactly one unit of that column's weight.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

  // number of operand bit pairs that land in weight column j
  function automatic int pairsOf(int n, int j);
    int hiSide;
    hiSide = 2 * n - 1 - j;
    return (j + 1 < hiSide) ? j + 1 : hiSide;
  endfunction

  // smallest opA index feeding column j
  function automatic int lowIdx(int n, int j);
    return (j > n - 1) ? j - (n - 1) : 0;
  endfunction

  function automatic int colWidth(int n, int rep, int pad, int j);
    return rep * pairsOf(n, j) + pad;
  endfunction

  // first stream bit of column j
  function automatic int colOffset(int n, int rep, int pad, int j);
    int acc;
    acc = 0;
    for (int m = 0; m < j; m++) acc += colWidth(n, rep, pad, m);
    return acc;
  endfunction

  function automatic int streamBits(int n, int rep, int pad);
    return colOffset(n, rep, pad, 2 * n - 1);
  endfunction

endpackage

// File: rtl/bsm_stream_gen.sv
module bsm_stream_gen
  import bsm_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int REP   = 8,
  parameter int PAD   = 4,
  localparam int NCOL  = 2 * WIDTH - 1,
  localparam int SBITS = streamBits(WIDTH, REP, PAD)
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [SBITS-1:0] cleanStream
);

  for (genvar j = 0; j < NCOL; j++) begin : gCol
    localparam int OFF = colOffset(WIDTH, REP, PAD, j);
    localparam int NP  = pairsOf(WIDTH, j);
    localparam int LO  = lowIdx(WIDTH, j);

    for (genvar q = 0; q < PAD; q++) begin : gPad
      assign cleanStream[OFF+q] = 1'b1;
    end

    for (genvar p = 0; p < NP; p++) begin : gPair
      localparam int IA = LO + p;
      localparam int IB = j - IA;
      logic pairBit;
      assign pairBit = opA[IA] & opB[IB];
      for (genvar r = 0; r < REP; r++) begin : gRep
        assign cleanStream[OFF+PAD+p*REP+r] = pairBit;
      end
    end
  end

endmodule

// File: rtl/bsm_column_count.sv
module bsm_column_count #(
  parameter int W   = 12,
  parameter int REP = 8,
  parameter int VW  = 4
) (
  input  logic [W-1:0]  colBits,
  output logic [VW-1:0] colVal
);

  int onesCnt;

  always_comb begin
    onesCnt = 0;
    for (int n = 0; n < W; n++) onesCnt += int'(colBits[n]);
    colVal = VW'(onesCnt / REP);
  end

endmodule

// File: rtl/bsm_combiner.sv
module bsm_combiner #(
  parameter int NCOL = 15,
  parameter int VW   = 4,
  parameter int PW   = 16
) (
  input  logic [NCOL-1:0][VW-1:0] colVals,
  output logic [PW-1:0]           sumOut
);

  always_comb begin
    sumOut = '0;
    for (int j = 0; j < NCOL; j++) sumOut = sumOut + (PW'(colVals[j]) << j);
  end

endmodule

// File: rtl/bsm_multiplier.sv
module bsm_multiplier
  import bsm_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int REP   = 8,
  parameter int PAD   = 4,
  localparam int SBITS = streamBits(WIDTH, REP, PAD),
  localparam int PW    = 2 * WIDTH
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [SBITS-1:0] faultMask,
  output logic [SBITS-1:0] rawStream,
  output logic [PW-1:0]    product
);

  localparam int NCOL = 2 * WIDTH - 1;
  localparam int VW   = $clog2(WIDTH + 1);

  logic [SBITS-1:0]         cleanStream;
  logic [NCOL-1:0][VW-1:0]  colVals;

  bsm_stream_gen #(.WIDTH(WIDTH), .REP(REP), .PAD(PAD)) uGen (
    .opA(opA),
    .opB(opB),
    .cleanStream(cleanStream)
  );

  assign rawStream = cleanStream ^ faultMask;

  for (genvar j = 0; j < NCOL; j++) begin : gCnt
    localparam int OFF = colOffset(WIDTH, REP, PAD, j);
    localparam int CW  = colWidth(WIDTH, REP, PAD, j);
    bsm_column_count #(.W(CW), .REP(REP), .VW(VW)) uCnt (
      .colBits(rawStream[OFF+CW-1:OFF]),
      .colVal(colVals[j])
    );
  end

  bsm_combiner #(.NCOL(NCOL), .VW(VW), .PW(PW)) uSum (
    .colVals(colVals),
    .sumOut(product)
  );

endmodule

// File: rtl/bsm_multiplier_chk.sv
module bsm_multiplier_chk
  import bsm_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int REP   = 8,
  parameter int PAD   = 4,
  localparam int SBITS = streamBits(WIDTH, REP, PAD),
  localparam int PW    = 2 * WIDTH
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [SBITS-1:0] faultMask,
  input logic [SBITS-1:0] rawStream,
  input logic [PW-1:0]    product
);

  localparam int NCOL = 2 * WIDTH - 1;

  always_comb begin
    if (faultMask == '0) begin
      assert_exact_product_R1: assert (product == PW'(PW'(opA) * PW'(opB)))
        else $error("product mismatch with clean stream");
      assert_ones_total_R4: assert ($countones(rawStream) ==
          REP * $countones(opA) * $countones(opB) + NCOL * PAD)
        else $error("stream ones total wrong");
    end
    if (faultMask == '0 && (opA == '0 || opB == '0)) begin
      assert_zero_operand_R1: assert (product == '0)
        else $error("zero operand gave nonzero product");
    end
  end

  always_comb begin
    for (int j = 0; j < NCOL; j++) begin
      for (int q = 0; q < PAD; q++) begin
        assert_pad_ones_R3: assert (rawStream[colOffset(WIDTH, REP, PAD, j) + q] ==
            ~faultMask[colOffset(WIDTH, REP, PAD, j) + q])
          else $error("pad bit not constant one");
      end
    end
  end

endmodule

bind bsm_multiplier bsm_multiplier_chk #(.WIDTH(WIDTH), .REP(REP), .PAD(PAD)) uChk (
  .opA(opA),
  .opB(opB),
  .faultMask(faultMask),
  .rawStream(rawStream),
  .product(product)
);

// File: tb/sim_bsm_multiplier.sv
`timescale 1ns/1ps
module sim_bsm_multiplier;

  localparam int SB = 572;
  localparam int NC = 15;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0]    opA, opB;
  logic [SB-1:0] faultMask, rawStream;
  logic [15:0]   product;

  bsm_multiplier u0 (
    .opA(opA), .opB(opB), .faultMask(faultMask),
    .rawStream(rawStream), .product(product)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;
  int colOff [NC];
  int colW   [NC];
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [15:0] nextLfsr(logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  function automatic logic [SB-1:0] modelStream(logic [7:0] a, logic [7:0] b);
    logic [SB-1:0] s;
    int off;
    s = '0;
    off = 0;
    for (int j = 0; j < NC; j++) begin
      int lo, hi, p;
      lo = (j > 7) ? j - 7 : 0;
      hi = (j < 7) ? j : 7;
      for (int q = 0; q < 4; q++) s[off+q] = 1'b1;
      p = 0;
      for (int i = lo; i <= hi; i++) begin
        for (int r = 0; r < 8; r++) s[off+4+p*8+r] = a[i] & b[j-i];
        p++;
      end
      off += 4 + 8 * (hi - lo + 1);
    end
    return s;
  endfunction

  // flips in column j: u zeros raised, d ones lowered, scan starts at st
  function automatic logic [SB-1:0] colFlips(logic [SB-1:0] s, int j, int u, int d, int st);
    logic [SB-1:0] m;
    int ups, downs;
    m = '0; ups = 0; downs = 0;
    for (int t = 0; t < colW[j]; t++) begin
      int pos;
      pos = colOff[j] + ((st + t) % colW[j]);
      if (!s[pos] && ups < u) begin m[pos] = 1'b1; ups++; end
      else if (s[pos] && downs < d) begin m[pos] = 1'b1; downs++; end
    end
    return m;
  endfunction

  task automatic apply(logic [7:0] a, logic [7:0] b, logic [SB-1:0] m);
    @(posedge clk);
    opA = a; opB = b; faultMask = m;
    @(negedge clk);
  endtask

  task automatic chkProd(string tag, logic [15:0] exp);
    nChecks++;
    if (product !== exp) begin
      nFails++;
      $display("FAIL %s a=%0d b=%0d product actual=%0d expected=%0d", tag, opA, opB, product, exp);
    end
  endtask

  task automatic chkStream(string tag, logic [SB-1:0] exp);
    nChecks++;
    if (rawStream !== exp) begin
      nFails++;
      $display("FAIL %s a=%0d b=%0d stream actual=%h expected=%h", tag, opA, opB, rawStream, exp);
    end
  endtask

  task automatic chkInt(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic testReset();
    apply(8'd0, 8'd0, '0);
    chkProd("R1 idle zero", 16'd0);
    chkStream("R2 idle stream", modelStream(8'd0, 8'd0));
  endtask

  task automatic testExhaustive();
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++) begin
        apply(8'(a), 8'(b), '0);
        chkProd("R1 exhaustive", 16'(a * b));
      end
  endtask

  task automatic testLayout();
    logic [7:0] av [4] = '{8'hFF, 8'h0F, 8'hA5, 8'h81};
    logic [7:0] bv [4] = '{8'hFF, 8'hF0, 8'h3C, 8'h18};
    for (int n = 0; n < 4; n++) begin
      apply(av[n], bv[n], '0);
      chkStream("R2 layout", modelStream(av[n], bv[n]));
      chkInt("R4 ones total", $countones(rawStream),
             8 * $countones(av[n]) * $countones(bv[n]) + 60);
    end
  endtask

  task automatic testPads();
    logic [SB-1:0] m;
    m = '0;
    for (int j = 0; j < NC; j++) m[colOff[j] + (j % 4)] = 1'b1;
    apply(8'h00, 8'h00, m);
    for (int j = 0; j < NC; j++)
      for (int q = 0; q < 4; q++)
        chkInt("R3 pad bit", int'(rawStream[colOff[j]+q]), (q == j % 4) ? 0 : 1);
  endtask

  task automatic testXor();
    logic [SB-1:0] m;
    for (int w = 0; w < SB; w++) begin
      lfsr = nextLfsr(lfsr);
      m[w] = lfsr[0];
    end
    apply(8'h5A, 8'hC3, m);
    chkStream("R5 xor", modelStream(8'h5A, 8'hC3) ^ m);
  endtask

  task automatic testUpOnly();
    logic [SB-1:0] s, m;
    s = modelStream(8'h0F, 8'hF0);
    m = '0;
    for (int j = 0; j < NC; j++) m |= colFlips(s, j, 3, 0, 0);
    apply(8'h0F, 8'hF0, m);
    chkProd("R6 up 3 all columns", 16'(15 * 240));
  endtask

  task automatic testDownOnly();
    logic [SB-1:0] s, m;
    s = modelStream(8'hFF, 8'hFF);
    m = '0;
    for (int j = 0; j < NC; j++) m |= colFlips(s, j, 0, 4, 5);
    apply(8'hFF, 8'hFF, m);
    chkProd("R7 down 4 all columns", 16'd65025);
  endtask

  task automatic testMixed();
    logic [SB-1:0] s, m;
    logic [7:0] a, b;
    for (int it = 0; it < 300; it++) begin
      lfsr = nextLfsr(lfsr); a = lfsr[7:0];
      lfsr = nextLfsr(lfsr); b = lfsr[7:0];
      s = modelStream(a, b);
      m = '0;
      for (int j = 0; j < NC; j++) begin
        int u, d;
        lfsr = nextLfsr(lfsr);
        u = int'(lfsr[1:0]);
        d = int'(lfsr[4:2]) % 5;
        if (it % 4 == 0) begin u = 3; d = 4; end
        m |= colFlips(s, j, u, d, int'(lfsr[11:5]) + it);
      end
      apply(a, b, m);
      chkProd("R8 mixed flips", 16'(int'(a) * int'(b)));
    end
  endtask

  task automatic testOverUp();
    logic [SB-1:0] s;
    s = modelStream(8'h0F, 8'h0F);
    apply(8'h0F, 8'h0F, colFlips(s, 7, 4, 0, 0));
    chkProd("R9 up 4 col7", 16'(225 + 128));
    s = modelStream(8'h7F, 8'hFF);
    apply(8'h7F, 8'hFF, colFlips(s, 14, 4, 0, 0));
    chkProd("R9 up 4 col14", 16'((127 * 255 + 16384) % 65536));
  endtask

  task automatic testOverDown();
    logic [SB-1:0] s;
    s = modelStream(8'h0F, 8'h0F);
    apply(8'h0F, 8'h0F, colFlips(s, 3, 0, 5, 0));
    chkProd("R10 down 5 col3", 16'(225 - 8));
    s = modelStream(8'hFF, 8'hFF);
    apply(8'hFF, 8'hFF, colFlips(s, 0, 0, 5, 0));
    chkProd("R10 down 5 col0", 16'(65025 - 1));
  endtask

  initial begin
    int off;
    off = 0;
    for (int j = 0; j < NC; j++) begin
      int np;
      np = (j + 1 < 15 - j) ? j + 1 : 15 - j;
      colOff[j] = off;
      colW[j] = 8 * np + 4;
      off += colW[j];
    end
    opA = '0; opB = '0; faultMask = '0;
    testReset();
    testLayout();
    testPads();
    testXor();
    testUpOnly();
    testDownOnly();
    testMixed();
    testOverUp();
    testOverDown();
    testExhaustive();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog run did not complete");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule